// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic use a 128K x 8 asynchronous static RAM. The RAM has a chip-select pair, one select active low and one active high, plus active-low write-enable and output-enable strobes. A host hands the controller one read or one write at a time through a valid/ready port. The controller then sequences the strobes and the split data bus (data out, drive enable, data in). Each phase lasts a whole number of clock cycles, and that number is derived from minimum nanosecond timings given as parameters.

A read asserts both selects and output enable for the read phase and captures the data on the phase's last cycle. The data comes back with a one-cycle valid pulse. A write asserts both selects and write enable together, with output enable held high, and drives data for the whole pulse. Write enable rises first and ends the write, while the selects, address and data stay put for one more cycle. A standby input parks the RAM deselected for data retention. On release, a recovery wait of one read-cycle time passes before the next access.

States: IDLE (deselected, ready), RD_ACC (read access), WR_PULSE (write enable low), WR_END (write enable high, still selected and driving), WR_TAIL (deselected padding, used when the write cycle needs it), STBY (retention), RECOV (post-retention wait). Transitions: IDLE to RD_ACC on an accepted read, IDLE to WR_PULSE on an accepted write, IDLE to STBY on standby request, RD_ACC to IDLE when its count expires, WR_PULSE to WR_END when its count expires, WR_END to WR_TAIL or IDLE, WR_TAIL to IDLE when its count expires, STBY to RECOV on standby release, RECOV to IDLE when its count expires.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is active and right after it, both selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rd_valid`=0. Once reset is released and no standby is requested, `req_ready` is 1.
- R2: The RAM counts as selected only when `mem_sel_n`=0 and `mem_sel`=1. Outside an access, both selects stay in their inactive levels together.
- R3: A read is accepted on a rising edge with `req_valid`=1 and `req_ready`=1. It holds the address with both selects asserted, `mem_we_n`=1 and `mem_oe_n`=0. `rd_valid` is high for exactly one cycle, N_RD rising edges after the accepting edge, with `rd_data` holding the RAM data at that address.
- R4: An accepted write asserts both selects and drives `mem_we_n`=0 in the same edge. `mem_we_n` stays low for exactly N_WP cycles. `mem_oe_n` stays 1 and `mem_dq_oe` stays 1 throughout.
- R5: A write ends with `mem_we_n` rising while both selects are still asserted. Address and write data are unchanged from the first write cycle through that cycle. The RAM is deselected on the following edge.
- R6: `mem_dq_oe` is 1 only from the first cycle of `mem_we_n` low until the cycle after `mem_we_n` rises, and is 0 at all other times.
- R7: Each phase length is ceil(t_ns / CLK_NS), taking the largest of the minimums that apply to that phase. With the defaults (10 ns clock; read cycle and address access 70, output-enable access 40, write cycle 70, select and address to end of write 60, write pulse 50, data setup 30), N_RD = 7, N_WP = 6 and N_RC = 7. Elaboration fails if any count is below one.
- R8: While `standby_req`=1 in idle, `req_ready`=0, the RAM stays deselected and a waiting request is neither accepted nor written.
- R9: After `standby_req` falls, `req_ready` stays 0 for exactly N_RC cycles after the edge that sees the release, then returns to 1.
- R10: A write keeps the RAM occupied for at least the write cycle time: no new access starts within N_RD = 7 edges of a write's accepting edge.
- R11: `req_ready` is 0 during any access and returns to 1 on the 7th edge after the accepting edge, for reads and for writes with the default timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| standby_req | input | 1 | Request retention standby (level) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8 | Read data |
| mem_addr | output | 17 | RAM address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
Every request's result has a fixed due cycle. Read data is due N_RD = 7 edges after the accepting edge. `req_ready` returns on that same 7th edge for reads and writes alike. The write-enable pulse spans exactly 6 cycles, the select pair drops on the edge after write enable rises, and after a standby release the port is ready again exactly 7 cycles after the edge that sees it. The driver records each accepting cycle and pushes the expected byte and due cycle into a queue. The monitor and the behavioural RAM sample on falling edges, pop those entries and compare the cycle and the value, so every check lands half a cycle after the register that produces the result.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_PULSE,
        ST_WR_END,
        ST_WR_TAIL,
        ST_STBY,
        ST_RECOV
    } asram_state_e;

    // whole clock cycles covering a minimum time
    function automatic int cyc_ceil(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] rd_data
);
    // address and write data are held until the next accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture) begin
            rd_data <= mem_dq_in;
        end
    end

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int N_RD   = 7,
    parameter int N_WP   = 6,
    parameter int N_TAIL = 0,
    parameter int N_RC   = 7,
    parameter int CW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_req,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          cnt_done,
    output logic          req_ready,
    output logic          accept,
    output logic          capture,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          rd_valid,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_dq_oe
);
    localparam logic [CW-1:0] L_RD   = CW'(N_RD - 1);
    localparam logic [CW-1:0] L_WP   = CW'(N_WP - 1);
    localparam logic [CW-1:0] L_RC   = CW'(N_RC - 1);
    localparam logic [CW-1:0] L_TAIL = CW'((N_TAIL > 0) ? N_TAIL - 1 : 0);

    asram_state_e state_q, state_d;

    assign req_ready = (state_q == ST_IDLE) && !standby_req;
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_RD_ACC) && cnt_done;

    // next state and phase counter load
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (standby_req) begin
                    state_d = ST_STBY;
                end else if (req_valid) begin
                    cnt_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_PULSE;
                        cnt_val = L_WP;
                    end else begin
                        state_d = ST_RD_ACC;
                        cnt_val = L_RD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (cnt_done) state_d = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (cnt_done) state_d = ST_WR_END;
            end
            ST_WR_END: begin
                if (N_TAIL > 0) begin
                    state_d  = ST_WR_TAIL;
                    cnt_load = 1'b1;
                    cnt_val  = L_TAIL;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_TAIL: begin
                if (cnt_done) state_d = ST_IDLE;
            end
            ST_STBY: begin
                if (!standby_req) begin
                    state_d  = ST_RECOV;
                    cnt_load = 1'b1;
                    cnt_val  = L_RC;
                end
            end
            ST_RECOV: begin
                if (cnt_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered strobes, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            rd_valid  <= 1'b0;
        end else begin
            mem_sel_n <= !(state_d inside {ST_RD_ACC, ST_WR_PULSE, ST_WR_END});
            mem_sel   <=  (state_d inside {ST_RD_ACC, ST_WR_PULSE, ST_WR_END});
            mem_we_n  <=  (state_d != ST_WR_PULSE);
            mem_oe_n  <=  (state_d != ST_RD_ACC);
            mem_dq_oe <=  (state_d inside {ST_WR_PULSE, ST_WR_END});
            rd_valid  <=  capture;
        end
    end

    p_we_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_sel_n && mem_sel && mem_oe_n && mem_dq_oe));

    p_drive_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n || !$past(mem_we_n)));

    p_we_rise_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_sel_n && mem_sel));

    p_deselect_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> (mem_sel_n && !mem_sel && !mem_dq_oe));

    p_rdvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_standby_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby_req |-> !req_ready);

    p_ready_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW      = 17,
    parameter int DW      = 8,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_OE_NS = 40,
    parameter int T_WC_NS = 70,
    parameter int T_CW_NS = 60,
    parameter int T_AW_NS = 60,
    parameter int T_WP_NS = 50,
    parameter int T_DW_NS = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_req,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int C_RC = cyc_ceil(T_RC_NS, CLK_NS);
    localparam int C_AA = cyc_ceil(T_AA_NS, CLK_NS);
    localparam int C_OE = cyc_ceil(T_OE_NS, CLK_NS);
    localparam int C_WC = cyc_ceil(T_WC_NS, CLK_NS);
    localparam int C_CW = cyc_ceil(T_CW_NS, CLK_NS);
    localparam int C_AW = cyc_ceil(T_AW_NS, CLK_NS);
    localparam int C_WP = cyc_ceil(T_WP_NS, CLK_NS);
    localparam int C_DW = cyc_ceil(T_DW_NS, CLK_NS);

    localparam int N_RD   = imax(C_RC, imax(C_AA, C_OE));
    localparam int N_WP   = imax(imax(C_WP, C_DW), imax(C_CW, C_AW));
    localparam int N_TAIL = (C_WC > N_WP + 1) ? (C_WC - N_WP - 1) : 0;
    localparam int N_RC   = C_RC;
    localparam int N_MAX  = imax(imax(N_RD, N_WP), imax(N_RC, N_TAIL));
    localparam int CW     = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    if (C_RC < 1 || C_AA < 1 || C_OE < 1 || C_WC < 1 ||
        C_CW < 1 || C_AW < 1 || C_WP < 1 || C_DW < 1) begin : g_bad_timing
        $error("asram_ctrl: a phase rounds to fewer than one clock cycle");
    end

    logic          accept;
    logic          capture;
    logic          cnt_load;
    logic          cnt_done;
    logic [CW-1:0] cnt_val;

    asram_fsm #(
        .N_RD   (N_RD),
        .N_WP   (N_WP),
        .N_TAIL (N_TAIL),
        .N_RC   (N_RC),
        .CW     (CW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_req (standby_req),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .cnt_done    (cnt_done),
        .req_ready   (req_ready),
        .accept      (accept),
        .capture     (capture),
        .cnt_load    (cnt_load),
        .cnt_val     (cnt_val),
        .rd_valid    (rd_valid),
        .mem_sel_n   (mem_sel_n),
        .mem_sel     (mem_sel),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_dq_oe   (mem_dq_oe)
    );

    asram_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rd_data)
    );

    // address and data may only move on or after the edge that ends a write
    p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RD = 7;
    localparam int N_WP = 6;
    localparam int N_RC = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_req = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out;
    logic [7:0]  mem_dq_in = '0;
    logic [16:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct { logic [7:0] d; int due; } exp_t;
    exp_t exp_q[$];
    logic [7:0] ref_mem [int];
    logic [7:0] ram [int];

    asram_ctrl #(.CLK_NS(CLK_PERIOD)) uut (
        .clk(clk), .rst_n(rst_n), .standby_req(standby_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural RAM with strobe checks, sampled on falling edges
    bit          wr_prev = 0, post_wr = 0;
    int          wr_len = 0;
    logic [16:0] wa;
    logic [7:0]  wd;
    always @(negedge clk) begin
        bit sel_on, wr_on;
        if (rst_n) begin
            sel_on = !mem_sel_n && mem_sel;
            wr_on  = sel_on && !mem_we_n;
            if (wr_on) begin
                if (wr_len == 0) begin
                    wa = mem_addr;
                    wd = mem_dq_out;
                end else begin
                    chk(mem_addr == wa, "R5 address held in write", int'(mem_addr), int'(wa));
                    chk(mem_dq_out == wd, "R5 data held in write", int'(mem_dq_out), int'(wd));
                end
                chk(mem_oe_n && mem_dq_oe, "R4 oe high and bus driven", {mem_oe_n, mem_dq_oe}, 2'b11);
                wr_len++;
            end else if (wr_prev) begin
                chk(wr_len == N_WP, "R4 R7 write pulse length", wr_len, N_WP);
                chk(sel_on && mem_dq_oe, "R5 selected at write end", {sel_on, mem_dq_oe}, 2'b11);
                chk(mem_addr == wa && mem_dq_out == wd, "R5 hold at write end", int'(mem_addr), int'(wa));
                ram[int'(wa)] = wd;
                wr_len = 0;
                post_wr = 1;
            end else if (post_wr) begin
                chk(!sel_on && !mem_dq_oe, "R5 R6 deselect after write", {sel_on, mem_dq_oe}, 2'b00);
                post_wr = 0;
            end else if (mem_dq_oe) begin
                chk(0, "R6 bus driven outside write", 1, 0);
            end
            if (sel_on && mem_we_n && !mem_oe_n)
                mem_dq_in <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
            else
                mem_dq_in <= 8'h00;
            wr_prev = wr_on;
        end
    end

    // scoreboard monitor
    bit rv_prev = 0;
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (rd_valid && rv_prev) chk(0, "R3 rd_valid longer than one cycle", 1, 0);
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected rd_valid", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e.d, "R3 read data", int'(rd_data), int'(e.d));
                    chk(cyc == e.due, "R3 R7 read latency", cyc, e.due);
                end
            end
            rv_prev = rd_valid;
        end
    end

    task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
        int acc, n;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        acc = cyc;
        req_valid = 1'b0;
        if (w) ref_mem[int'(a)] = d;
        else exp_q.push_back('{ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00, acc + N_RD});
        n = 0;
        while (!req_ready) begin
            n++;
            @(negedge clk);
        end
        chk(n == N_RD, "R10 R11 busy cycles after accept", n, N_RD);
    endtask

    initial begin
        logic [16:0] addrs [8];
        logic [7:0]  datas [8];
        int n;
        repeat (3) @(negedge clk);
        chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
            "R1 R2 reset strobes", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        for (int i = 0; i < 8; i++) begin
            addrs[i] = 17'($urandom);
            datas[i] = 8'($urandom) | 8'h01;
            issue(1'b1, addrs[i], datas[i]);
        end
        for (int i = 7; i >= 0; i--) issue(1'b0, addrs[i], 8'h00);

        issue(1'b1, 17'h00000, 8'hA5);
        issue(1'b1, 17'h1FFFF, 8'h5A);
        issue(1'b0, 17'h1FFFF, 8'h00);
        issue(1'b0, 17'h00000, 8'h00);
        issue(1'b1, 17'h00000, 8'h3C);
        issue(1'b0, 17'h00000, 8'h00);
        issue(1'b0, 17'h00000, 8'h00);

        // standby: request present but must not be taken
        @(negedge clk);
        standby_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00123; req_wdata = 8'hEE;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!req_ready && mem_sel_n && !mem_sel && mem_we_n,
                "R8 R2 standby keeps ram deselected", {req_ready, mem_sel_n, mem_sel, mem_we_n}, 4'b0101);
        end
        req_valid = 1'b0;
        standby_req = 1'b0;
        n = 0;
        @(negedge clk);
        while (!req_ready && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(n == N_RC, "R9 recovery cycles", n, N_RC);
        issue(1'b0, 17'h00123, 8'h00);

        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual %0d expected done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule